// File: doc/BRIEF.md
# Single-Wire Humidity Sensor Read Controller

This block runs one read transaction on a single open-drain data line shared with a humidity/temperature sensor. On a request it pulls the line low for a programmable number of microseconds, then lets go and measures every high interval that the sensor produces. Each finished high interval becomes one bit: long intervals are ones, short intervals are zeros, and the decision point is a programmable microsecond threshold. Low intervals carry no information and are only used to close the preceding high interval.

The bits move through a 40-bit shift register, so the word that remains after the line goes quiet holds the 40 most recent high intervals. Leading intervals such as the sensor's acknowledge pulse, stray glitches or the gap after release are shifted out, and a missing acknowledge does not shift the data. The 40 bits are four data bytes and one checksum byte. A read ends with a one-cycle success strobe or a one-cycle failure strobe and a failure code. After any failure the controller waits out a long holdoff before it accepts another request.

The state machine has five states. ST_IDLE waits for a request (transition go). ST_START_LOW drives the line low and leaves on release once the start time has elapsed. ST_CAPTURE measures intervals and leaves on quiet when no edge has been seen for the idle time. ST_DECODE lasts one cycle and leaves on pass to ST_IDLE or on reject to ST_HOLDOFF. ST_HOLDOFF leaves on expire back to ST_IDLE.

Top module: `sws_sensor_rx`

## Requirements
- R1: A request in ST_IDLE makes line_drive_low high for exactly start_len_us times CLK_PER_US clock cycles, with start_len_us at least 1. The controller then releases the line and stays busy while it captures.
- R2: A finished high interval (a rise followed by a fall on the synchronized line) decodes as 1 when its length in microseconds exceeds thresh_us and as 0 otherwise. The lengths of low intervals have no effect on the bits.
- R3: Only the 40 most recent finished high intervals form the frame. Extra earlier intervals, such as short glitches or the acknowledge pulse, and a missing acknowledge do not change the decoded data.
- R4: The first of the 40 bits received is the MSB of data_out[31:24], and the bytes follow in arrival order, each MSB first. The fifth byte (last 8 bits) is the checksum.
- R5: Capture ends once the synchronized line has shown no edge for IDLE_US microseconds. The result strobe follows within a few cycles.
- R6: When at least 40 intervals were finished, none was too long, and the checksum equals the low 8 bits of the sum of the four data bytes, done pulses for one cycle with sum_ok=1 and data_out set to the four data bytes.
- R7: When fewer than 40 high intervals were finished, fail pulses with fail_code=1 (no response).
- R8: When at least 40 intervals were finished and any finished high interval exceeded MAXHI_US, fail pulses with fail_code=2 (framing).
- R9: When the frame is complete and well formed but the checksum does not match, fail pulses with fail_code=3 and sum_ok=0. data_out still shows the received data bytes.
- R10: After a failure the controller stays busy for exactly HOLDOFF_US times CLK_PER_US cycles, counted from the cycle fail is high. During that time requests are ignored and the line is never driven.
- R11: After reset the line is released, busy, done and fail are 0, fail_code is 0 and data_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Single-cycle request to start a read |
| start_len_us | input | 16 | Start-low duration in microseconds |
| thresh_us | input | 8 | High-time decision threshold in microseconds |
| line_in | input | 1 | Raw level of the data line |
| line_drive_low | output | 1 | 1 pulls the open-drain line low |
| busy | output | 1 | High outside ST_IDLE |
| data_out | output | 32 | Four received data bytes, first byte in [31:24] |
| sum_ok | output | 1 | Checksum of the last decoded frame matched |
| done | output | 1 | One-cycle success strobe |
| fail | output | 1 | One-cycle failure strobe |
| fail_code | output | 2 | 1 no response, 2 framing, 3 checksum; 0 with done |

## Verification
The assertions take several things for granted about the inputs. start_len_us is at least 1 while a read runs. thresh_us stays below the framing limit. Every line level lasts for several microseconds, so the interval meter sees clean edges through the synchronizer and an interval that is too long still ends before the idle timeout. The bench sensor model uses low intervals of 20 µs, high intervals between 5 µs and 170 µs, and an idle time of 200 µs. It changes start_len_us and thresh_us only while the controller is idle.

// File: rtl/sws_pkg.sv
package sws_pkg;

    localparam int FRAME_BITS = 40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_LOW,
        ST_CAPTURE,
        ST_DECODE,
        ST_HOLDOFF
    } sws_state_e;

    typedef enum logic [1:0] {
        FC_NONE        = 2'd0,
        FC_NO_RESPONSE = 2'd1,
        FC_FRAMING     = 2'd2,
        FC_CHECKSUM    = 2'd3
    } sws_fail_e;

endpackage

// File: rtl/sws_sync.sv
module sws_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // idle level of a pulled-up line is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sws_tick.sv
module sws_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pre;

    assign tick = (pre == PW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pre <= '0;
        else if (restart || tick) pre <= '0;
        else                     pre <= pre + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_gap
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R1
        end
    endgenerate
endmodule

// File: rtl/sws_phase_meter.sv
module sws_phase_meter #(
    parameter int MAXHI_US = 150,
    parameter int IDLE_US  = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       lvl,
    input  logic       tick,
    input  logic [7:0] thresh,
    output logic       ph_done,
    output logic       ph_bit,
    output logic       ph_long,
    output logic       idle_hit
);
    localparam int IW = $clog2(IDLE_US + 1);

    logic          prev;
    logic          in_high;
    logic [7:0]    hi_us;
    logic [IW-1:0] idle_us;

    assign idle_hit = (idle_us == IW'(IDLE_US));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev    <= 1'b1;
            in_high <= 1'b0;
            hi_us   <= '0;
            idle_us <= '0;
            ph_done <= 1'b0;
            ph_bit  <= 1'b0;
            ph_long <= 1'b0;
        end else begin
            ph_done <= 1'b0;
            prev    <= lvl;
            if (!arm) begin
                in_high <= 1'b0;
                hi_us   <= '0;
                idle_us <= '0;
            end else if (lvl && !prev) begin
                in_high <= 1'b1;
                hi_us   <= '0;
                idle_us <= '0;
            end else if (!lvl && prev) begin
                in_high <= 1'b0;
                idle_us <= '0;
                if (in_high) begin
                    ph_done <= 1'b1;
                    ph_bit  <= (hi_us > thresh);
                    ph_long <= (hi_us > 8'(MAXHI_US));
                end
            end else if (tick) begin
                if (in_high && hi_us != 8'hFF) hi_us <= hi_us + 1'b1;
                if (!idle_hit) idle_us <= idle_us + 1'b1;
            end
        end
    end

    AST_PH_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ph_done |-> !in_high); // R2
endmodule

// File: rtl/sws_sensor_rx.sv
module sws_sensor_rx
    import sws_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int IDLE_US    = 200,
    parameter int MAXHI_US   = 150,
    parameter int HOLDOFF_US = 2000000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_req,
    input  logic [15:0] start_len_us,
    input  logic [7:0]  thresh_us,
    input  logic        line_in,
    output logic        line_drive_low,
    output logic        busy,
    output logic [31:0] data_out,
    output logic        sum_ok,
    output logic        done,
    output logic        fail,
    output logic [1:0]  fail_code
);
    localparam int UW = ($clog2(HOLDOFF_US + 1) > 17) ? $clog2(HOLDOFF_US + 1) : 17;
    localparam int CW = $clog2(FRAME_BITS + 2);

    sws_state_e state, nxt;
    sws_fail_e  verdict;

    logic                  lvl, tick, restart;
    logic                  ph_done, ph_bit, ph_long, idle_hit;
    logic [FRAME_BITS-1:0] sh;
    logic [CW-1:0]         cnt;
    logic                  long_seen;
    logic [UW-1:0]         ucnt;
    logic [7:0]            sum_calc;
    logic                  start_last, hold_last;

    sws_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(line_in), .q(lvl)
    );

    sws_tick #(.DIV(CLK_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
    );

    sws_phase_meter #(.MAXHI_US(MAXHI_US), .IDLE_US(IDLE_US)) u_meter (
        .clk(clk), .rst_n(rst_n), .arm(state == ST_CAPTURE), .lvl(lvl),
        .tick(tick), .thresh(thresh_us), .ph_done(ph_done), .ph_bit(ph_bit),
        .ph_long(ph_long), .idle_hit(idle_hit)
    );

    assign sum_calc   = sh[39:32] + sh[31:24] + sh[23:16] + sh[15:8];
    assign start_last = tick && ((ucnt + UW'(1)) >= UW'(start_len_us));
    assign hold_last  = tick && ((ucnt + UW'(1)) >= UW'(HOLDOFF_US));

    always_comb begin
        if (cnt < CW'(FRAME_BITS))   verdict = FC_NO_RESPONSE;
        else if (long_seen)          verdict = FC_FRAMING;
        else if (sum_calc != sh[7:0]) verdict = FC_CHECKSUM;
        else                         verdict = FC_NONE;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start_req)  nxt = ST_START_LOW;            // go
            ST_START_LOW: if (start_last) nxt = ST_CAPTURE;              // release
            ST_CAPTURE:   if (idle_hit)   nxt = ST_DECODE;               // quiet
            ST_DECODE:    nxt = (verdict == FC_NONE) ? ST_IDLE : ST_HOLDOFF; // pass / reject
            ST_HOLDOFF:   if (hold_last)  nxt = ST_IDLE;                 // expire
            default:      nxt = ST_IDLE;
        endcase
    end

    assign restart = (state == ST_IDLE && start_req) ||
                     (state == ST_DECODE && verdict != FC_NONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // microsecond counter within a state, frame shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ucnt      <= '0;
            sh        <= '0;
            cnt       <= '0;
            long_seen <= 1'b0;
        end else begin
            if (nxt != state) ucnt <= '0;
            else if (tick)    ucnt <= ucnt + 1'b1;

            if (state == ST_IDLE && start_req) begin
                sh        <= '0;
                cnt       <= '0;
                long_seen <= 1'b0;
            end else if (state == ST_CAPTURE && ph_done) begin
                sh        <= {sh[FRAME_BITS-2:0], ph_bit};
                if (cnt != CW'(FRAME_BITS)) cnt <= cnt + 1'b1;
                long_seen <= long_seen | ph_long;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out  <= '0;
            sum_ok    <= 1'b0;
            done      <= 1'b0;
            fail      <= 1'b0;
            fail_code <= 2'd0;
        end else begin
            done <= 1'b0;
            fail <= 1'b0;
            if (state == ST_DECODE) begin
                data_out  <= sh[39:8];
                sum_ok    <= (sum_calc == sh[7:0]);
                fail_code <= verdict;
                if (verdict == FC_NONE) done <= 1'b1;
                else                    fail <= 1'b1;
            end
        end
    end

    always_comb begin
        line_drive_low = (state == ST_START_LOW);
        busy           = (state != ST_IDLE);
    end

    AST_RELEASE_TO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_drive_low) |-> state == ST_CAPTURE); // R1
    AST_DONE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sum_ok); // R6
    AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail)); // R6
    AST_FAIL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> fail_code != 2'd0); // R7
    AST_NO_RESP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && fail_code == 2'd1) |-> cnt < CW'(FRAME_BITS)); // R7
    AST_HOLDOFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLDOFF && start_req) |=> !line_drive_low); // R10
endmodule

// File: tb/sim_sws_sensor_rx.sv
module sim_sws_sensor_rx;
    localparam int CLK_PERIOD = 10;
    localparam int CPU   = 2;
    localparam int IDLE  = 200;
    localparam int MAXHI = 150;
    localparam int HOLD  = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic [15:0] start_len_us = 16'd30;
    logic [7:0]  thresh_us = 8'd49;
    logic        sens_low = 1'b0;
    logic        line;
    logic        line_drive_low, busy, sum_ok, done, fail;
    logic [31:0] data_out;
    logic [1:0]  fail_code;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    logic        r_done, r_fail, r_ok;
    logic [1:0]  r_code;
    logic [31:0] r_data;

    assign line = !(line_drive_low || sens_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    sws_sensor_rx #(.CLK_PER_US(CPU), .IDLE_US(IDLE), .MAXHI_US(MAXHI), .HOLDOFF_US(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_len_us(start_len_us),
        .thresh_us(thresh_us), .line_in(line), .line_drive_low(line_drive_low),
        .busy(busy), .data_out(data_out), .sum_ok(sum_ok), .done(done), .fail(fail),
        .fail_code(fail_code)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n * CPU) @(negedge clk);
    endtask

    function automatic logic [39:0] mk(input logic [7:0] a, b, c, d);
        logic [7:0] s;
        s = a + b + c + d;
        return {a, b, c, d, s};
    endfunction

    // mode 0 normal, 1 no acknowledge, 2 glitches before acknowledge, 3 acknowledge only
    task automatic do_read(input int slen, input int th, input logic [39:0] frame,
                           input int mode, input int hi0, input int hi1, input int long_idx);
        int lowcyc;
        @(negedge clk);
        start_len_us = 16'(slen);
        thresh_us    = 8'(th);
        start_req    = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        lowcyc = 0;
        while (line_drive_low) begin
            lowcyc++;
            @(negedge clk);
        end
        chk("R1 start-low cycles", 64'(lowcyc), 64'(slen * CPU));
        chk("R1 busy in capture", 64'(busy), 64'd1);
        wait_us(27);
        if (mode == 2) begin
            for (int g = 0; g < 3; g++) begin
                sens_low = 1'b1; wait_us(5);
                sens_low = 1'b0; wait_us(5);
            end
        end
        if (mode != 1) begin
            sens_low = 1'b1; wait_us(80);
            sens_low = 1'b0; wait_us(80);
        end
        if (mode != 3) begin
            for (int i = 0; i < 40; i++) begin
                sens_low = 1'b1; wait_us(20);
                sens_low = 1'b0;
                wait_us((i == long_idx) ? 170 : (frame[39-i] ? hi1 : hi0));
            end
            sens_low = 1'b1; wait_us(20);
            sens_low = 1'b0;
        end
        r_done = 0; r_fail = 0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (done || fail) break;
        end
        r_done = done; r_fail = fail; r_ok = sum_ok; r_code = fail_code; r_data = data_out;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [39:0] fr;
        int hcnt;
        bit drv;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk("R11 line released", 64'(line_drive_low), 64'd0);
        chk("R11 busy", 64'(busy), 64'd0);
        chk("R11 done/fail", 64'({done, fail}), 64'd0);
        chk("R11 fail_code", 64'(fail_code), 64'd0);
        chk("R11 data_out", 64'(data_out), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // sweep of frames and start lengths: R2 R4 R5 R6
        for (int v = 0; v < 5; v++) begin
            fr = mk(8'(v * 53 + 7), 8'(v * 91 + 200), 8'(255 - v * 17), 8'(v * 29));
            do_read(20 + v * 9, 49, fr, 0, 28, 70, -1);
            chk("R5 result strobe after quiet", 64'(r_done), 64'd1);
            chk("R6 sum_ok", 64'(r_ok), 64'd1);
            chk("R4 byte order of data_out", 64'(r_data), 64'(fr[39:8]));
            chk("R6 success code", 64'(r_code), 64'd0);
        end

        // R3 missing acknowledge
        fr = mk(8'hA5, 8'h3C, 8'h0F, 8'hF0);
        do_read(25, 49, fr, 1, 28, 70, -1);
        chk("R3 no acknowledge done", 64'(r_done), 64'd1);
        chk("R3 no acknowledge data", 64'(r_data), 64'(fr[39:8]));

        // R3 extra leading glitches
        fr = mk(8'h12, 8'h34, 8'h56, 8'h78);
        do_read(25, 49, fr, 2, 28, 70, -1);
        chk("R3 glitches done", 64'(r_done), 64'd1);
        chk("R3 glitches data", 64'(r_data), 64'(fr[39:8]));

        // R2 threshold: 20/40 us highs with threshold 30 decode correctly
        fr = mk(8'hC3, 8'h81, 8'h7E, 8'h19);
        do_read(25, 30, fr, 0, 20, 40, -1);
        chk("R2 low threshold data", 64'(r_data), 64'(fr[39:8]));
        // same highs with threshold 49 are all zeros, checksum 0 matches
        do_read(25, 49, fr, 0, 20, 40, -1);
        chk("R2 high threshold done", 64'(r_done), 64'd1);
        chk("R2 high threshold data", 64'(r_data), 64'd0);

        // R9 checksum mismatch, then R10 holdoff
        fr = mk(8'h10, 8'h20, 8'h30, 8'h40) ^ 40'h1;
        do_read(25, 49, fr, 0, 28, 70, -1);
        chk("R9 fail strobe", 64'(r_fail), 64'd1);
        chk("R9 fail_code", 64'(r_code), 64'd3);
        chk("R9 sum_ok low", 64'(r_ok), 64'd0);
        chk("R9 data kept", 64'(r_data), 64'(fr[39:8]));
        hcnt = 1; drv = 0;
        for (int k = 0; k < HOLD * CPU + 100; k++) begin
            start_req = (k < 5);
            @(negedge clk);
            if (line_drive_low) drv = 1;
            if (busy) hcnt++;
            else break;
        end
        start_req = 1'b0;
        chk("R10 holdoff length", 64'(hcnt), 64'(HOLD * CPU));
        chk("R10 request ignored in holdoff", 64'(drv), 64'd0);

        // R8 framing: one high of 170 us
        fr = mk(8'h01, 8'h02, 8'h03, 8'h04);
        do_read(25, 49, fr, 0, 28, 70, 13);
        chk("R8 fail strobe", 64'(r_fail), 64'd1);
        chk("R8 fail_code", 64'(r_code), 64'd2);
        while (busy) @(negedge clk);

        // R7 acknowledge only
        do_read(25, 49, fr, 3, 28, 70, -1);
        chk("R7 fail strobe", 64'(r_fail), 64'd1);
        chk("R7 fail_code", 64'(r_code), 64'd1);
        while (busy) @(negedge clk);
        chk("R10 idle after holdoff", 64'(busy), 64'd0);

        finish_run();
    end
endmodule